// File: doc/BRIEF.md
# Hash Engine Command and Status Register File

This block is the software-facing front end of a DMA-driven hash accelerator. It holds the job descriptor registers: source address, destination address, key buffer address, source length, hash command and a cipher command word. It also holds a status word. Software accesses these registers as 32-bit words. Each stored field is masked to its legal bits. The two algorithm-select fields of the hash command are decoded into a compact algorithm code for the datapath.

A command write with a valid algorithm selection starts a job. The block then pulses `job_start` for one cycle and waits for `job_done` from the datapath. A small job controller sequences this with three states. JOB_IDLE moves to JOB_LAUNCH on an accepted, valid command write (the launch transition). JOB_LAUNCH always moves to JOB_WAIT one cycle later (the issue transition), and `job_start` is high only in JOB_LAUNCH. JOB_WAIT returns to JOB_IDLE when `job_done` is sampled high (the finish transition). That transition sets the completion flag.

The interrupt line is the completion flag gated by the interrupt-enable bit of the last accepted command. A command with an unknown algorithm, a command written while a job is running, or an access outside the register window does not start a job. Each of these sets its own sticky error bit in the status word.

Top module: `hash_cmd_regfile`

## Requirements
- R1: After reset every register reads zero, and `irq`, `job_start` and `err_flags` are low.
- R2: Registers are selected by word index: cipher command 4, status 7, source 8, destination 9, key 10, length 11, hash command 12. Read data appears on `reg_rdata` one cycle after `reg_rd`. Indices inside the window that hold no register read zero, and writes to them are dropped.
- R3: The source address keeps bits [30:0]. Destination and key addresses keep bits [30:3], with bits [2:0] forced to zero. The length keeps bits [27:0]. The hash command keeps only the bits set in 0x00147FFF. The cipher command is stored as written.
- R4: Command bits [6:4] select the algorithm, and `job_algo` carries its code: 000 gives MD5 (0), 010 gives SHA-1 (1), 100 gives SHA-224 (2), 101 gives SHA-256 (3). The value 110 selects the wide family, where bits [12:10] choose the variant: 000 gives SHA-512 (4), 001 gives SHA-384 (5), 010 gives SHA-512/256 (6).
- R5: Any other selection is stored but starts no job, and it sets status bit 0 (algorithm error).
- R6: An accepted valid command gives a single-cycle `job_start` in the cycle after the write. While it is high, `job_digest_mode` equals command bits [8:7] and `job_sg` equals command bit 18.
- R7: `job_done` sampled while waiting sets status bit 9 on the next cycle, whatever the interrupt enable. `job_done` at any other time has no effect.
- R8: `irq` equals status bit 9 AND command bit 9 of the last accepted command.
- R9: Status bits 9, 2, 1 and 0 are write-one-to-clear. Writing 0 leaves a bit unchanged. Clearing bit 9 drops `irq`. If a set and a clear of the same bit happen in one cycle, the set wins.
- R10: A command write during a running job is dropped: the stored command stays unchanged and status bit 2 (busy error) is set.
- R11: An access at word index 16 or above reads zero, changes no register and sets status bit 1 (window error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_widx | input | 10 | Word index of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| job_start | output | 1 | One-cycle job start pulse |
| job_done | input | 1 | Datapath completion |
| job_algo | output | 3 | Decoded algorithm code |
| job_digest_mode | output | 2 | Digest mode field of the command |
| job_sg | output | 1 | Scatter-gather enable of the command |
| src_addr | output | 32 | Masked source address |
| dst_addr | output | 32 | Masked destination address |
| key_addr | output | 32 | Masked key buffer address |
| src_len | output | 32 | Masked source length |
| err_flags | output | 3 | Status bits {busy, window, algorithm} errors |
| irq | output | 1 | Interrupt request |

## Verification
Reads return data one cycle after the strobe. The read driver queues the expected word, and the monitor compares `reg_rdata` just after the capturing edge. `job_start` is due in the first cycle after the command write and must be gone one cycle later. The status flag and `irq` are due one cycle after `job_done` is sampled in the waiting state. The bench samples each of these outputs at the falling edge that follows the capturing rising edge.

// File: rtl/hash_cmd_pkg.sv
package hash_cmd_pkg;

    typedef enum logic [2:0] {
        ALG_MD5        = 3'd0,
        ALG_SHA1       = 3'd1,
        ALG_SHA224     = 3'd2,
        ALG_SHA256     = 3'd3,
        ALG_SHA512     = 3'd4,
        ALG_SHA384     = 3'd5,
        ALG_SHA512_256 = 3'd6,
        ALG_NONE       = 3'd7
    } hash_algo_e;

    typedef enum logic [1:0] {
        JOB_IDLE   = 2'd0,
        JOB_LAUNCH = 2'd1,
        JOB_WAIT   = 2'd2
    } job_state_e;

    // word indices of the registers
    localparam int IDX_CIPHER = 4;
    localparam int IDX_STATUS = 7;
    localparam int IDX_SRC    = 8;
    localparam int IDX_DST    = 9;
    localparam int IDX_KEY    = 10;
    localparam int IDX_LEN    = 11;
    localparam int IDX_CMD    = 12;

    // status bit positions
    localparam int ST_ALGO_ERR  = 0;
    localparam int ST_WIN_ERR   = 1;
    localparam int ST_BUSY_ERR  = 2;
    localparam int ST_COMPLETE  = 9;

    // command bit positions
    localparam int CMD_IRQ_EN   = 9;
    localparam int CMD_SG_EN    = 18;

endpackage

// File: rtl/hash_algo_decode.sv
module hash_algo_decode
    import hash_cmd_pkg::*;
#(
    parameter bit WIDE_FAMILY = 1'b1
) (
    input  logic [2:0] sel_base,
    input  logic [2:0] sel_wide,
    output logic [2:0] algo_code,
    output logic       algo_ok
);

    logic       wide_ok;
    hash_algo_e wide_code;
    hash_algo_e base_code;
    logic       base_ok;

    generate
        if (WIDE_FAMILY) begin : g_wide
            always_comb begin
                wide_ok   = 1'b1;
                wide_code = ALG_NONE;
                unique case (sel_wide)
                    3'b000:  wide_code = ALG_SHA512;
                    3'b001:  wide_code = ALG_SHA384;
                    3'b010:  wide_code = ALG_SHA512_256;
                    default: wide_ok   = 1'b0;
                endcase
            end
        end else begin : g_narrow
            always_comb begin
                wide_ok   = 1'b0 & (|sel_wide);
                wide_code = ALG_NONE;
            end
        end
    endgenerate

    always_comb begin
        base_ok   = 1'b1;
        base_code = ALG_NONE;
        unique case (sel_base)
            3'b000:  base_code = ALG_MD5;
            3'b010:  base_code = ALG_SHA1;
            3'b100:  base_code = ALG_SHA224;
            3'b101:  base_code = ALG_SHA256;
            3'b110: begin
                base_ok   = wide_ok;
                base_code = wide_code;
            end
            default: base_ok = 1'b0;
        endcase
    end

    assign algo_ok   = base_ok;
    assign algo_code = base_ok ? base_code : ALG_NONE;

endmodule

// File: rtl/hash_job_fsm.sv
module hash_job_fsm
    import hash_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic done_i,
    output logic start_o,
    output logic busy_o,
    output logic finish_o
);

    job_state_e state_q;
    job_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= JOB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            JOB_IDLE:   if (launch_i) state_d = JOB_LAUNCH;
            JOB_LAUNCH: state_d = JOB_WAIT;
            JOB_WAIT:   if (done_i) state_d = JOB_IDLE;
            default:    state_d = JOB_IDLE;
        endcase
    end

    always_comb begin
        start_o  = 1'b0;
        busy_o   = 1'b1;
        finish_o = 1'b0;
        unique case (state_q)
            JOB_IDLE:   busy_o   = 1'b0;
            JOB_LAUNCH: start_o  = 1'b1;
            JOB_WAIT:   finish_o = done_i;
            default:    busy_o   = 1'b0;
        endcase
    end

    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o && busy_o);

    // R6
    launch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !busy_o) |=> start_o);

    // R7
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> !busy_o);

endmodule

// File: rtl/hash_reg_bank.sv
module hash_reg_bank
    import hash_cmd_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int WORDS    = 16,
    parameter int SRC_BITS = 31,
    parameter bit WIDE     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic             busy_i,
    input  logic             algo_ok_i,
    input  logic [2:0]       algo_code_i,
    input  logic             finish_i,
    output logic             cmd_hit_o,
    output logic [31:0]      cmd_masked_o,
    output logic [31:0]      rdata_o,
    output logic [31:0]      src_o,
    output logic [31:0]      dst_o,
    output logic [31:0]      key_o,
    output logic [31:0]      len_o,
    output logic [2:0]       algo_o,
    output logic [1:0]       digest_o,
    output logic             sg_o,
    output logic             irq_en_o,
    output logic             complete_o,
    output logic [2:0]       err_o
);

    localparam logic [31:0] SRC_MASK  = 32'((64'd1 << SRC_BITS) - 64'd1);
    localparam logic [31:0] DST_MASK  = SRC_MASK & 32'hFFFF_FFF8;
    localparam logic [31:0] LEN_MASK  = 32'h0FFF_FFFF;
    localparam logic [31:0] CMD_MASK  = WIDE ? 32'h0014_7FFF : 32'h0000_03FF;
    localparam logic [31:0] W1C_MASK  = (32'd1 << ST_COMPLETE) | (32'd1 << ST_BUSY_ERR)
                                      | (32'd1 << ST_WIN_ERR)  | (32'd1 << ST_ALGO_ERR);

    logic [31:0] cipher_q, status_q, src_q, dst_q, key_q, len_q, cmd_q;
    logic [2:0]  algo_q;
    logic [31:0] rd_mux;
    logic [31:0] st_set, st_clr;
    logic        in_win;
    logic        win_err, cmd_accept, busy_err, algo_bad;

    assign in_win = (32'(widx) < 32'(WORDS));

    function automatic logic hit(input logic [IDX_W-1:0] w, input int idx);
        return w == IDX_W'(idx);
    endfunction

    assign cmd_hit_o    = wr_en && in_win && hit(widx, IDX_CMD);
    assign cmd_masked_o = wdata & CMD_MASK;
    assign cmd_accept   = cmd_hit_o && !busy_i;
    assign busy_err     = cmd_hit_o && busy_i;
    assign algo_bad     = cmd_accept && !algo_ok_i;
    assign win_err      = (wr_en || rd_en) && !in_win;

    always_comb begin
        st_set = '0;
        st_set[ST_COMPLETE] = finish_i;
        st_set[ST_ALGO_ERR] = algo_bad;
        st_set[ST_WIN_ERR]  = win_err;
        st_set[ST_BUSY_ERR] = busy_err;
        st_clr = (wr_en && in_win && hit(widx, IDX_STATUS)) ? (wdata & W1C_MASK) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cipher_q <= '0;
            status_q <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            key_q    <= '0;
            len_q    <= '0;
            cmd_q    <= '0;
            algo_q   <= '0;
        end else begin
            status_q <= (status_q & ~st_clr) | st_set;
            if (wr_en && in_win) begin
                if (hit(widx, IDX_CIPHER)) cipher_q <= wdata;
                if (hit(widx, IDX_SRC))    src_q    <= wdata & SRC_MASK;
                if (hit(widx, IDX_DST))    dst_q    <= wdata & DST_MASK;
                if (hit(widx, IDX_KEY))    key_q    <= wdata & DST_MASK;
                if (hit(widx, IDX_LEN))    len_q    <= wdata & LEN_MASK;
            end
            if (cmd_accept) begin
                cmd_q  <= cmd_masked_o;
                algo_q <= algo_code_i;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit(widx, IDX_CIPHER)) rd_mux = cipher_q;
        if (hit(widx, IDX_STATUS)) rd_mux = status_q;
        if (hit(widx, IDX_SRC))    rd_mux = src_q;
        if (hit(widx, IDX_DST))    rd_mux = dst_q;
        if (hit(widx, IDX_KEY))    rd_mux = key_q;
        if (hit(widx, IDX_LEN))    rd_mux = len_q;
        if (hit(widx, IDX_CMD))    rd_mux = cmd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en) begin
            rdata_o <= in_win ? rd_mux : '0;
        end
    end

    assign src_o      = src_q;
    assign dst_o      = dst_q;
    assign key_o      = key_q;
    assign len_o      = len_q;
    assign algo_o     = algo_q;
    assign digest_o   = cmd_q[8:7];
    assign sg_o       = cmd_q[CMD_SG_EN];
    assign irq_en_o   = cmd_q[CMD_IRQ_EN];
    assign complete_o = status_q[ST_COMPLETE];
    assign err_o      = {status_q[ST_BUSY_ERR], status_q[ST_WIN_ERR], status_q[ST_ALGO_ERR]};

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit_o && busy_i) |=> $stable(cmd_q) && status_q[ST_BUSY_ERR]);

    // R11
    window_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_win) |=> (rdata_o == 32'd0) && status_q[ST_WIN_ERR]);

    // R9
    complete_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_win && hit(widx, IDX_STATUS) && wdata[ST_COMPLETE] && !finish_i)
        |=> !status_q[ST_COMPLETE]);

    // R5
    algo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && !algo_ok_i) |=> status_q[ST_ALGO_ERR]);

endmodule

// File: rtl/hash_cmd_regfile.sv
module hash_cmd_regfile
    import hash_cmd_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int WORDS    = 16,
    parameter int SRC_BITS = 31,
    parameter bit WIDE     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [IDX_W-1:0] reg_widx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             job_start,
    input  logic             job_done,
    output logic [2:0]       job_algo,
    output logic [1:0]       job_digest_mode,
    output logic             job_sg,
    output logic [31:0]      src_addr,
    output logic [31:0]      dst_addr,
    output logic [31:0]      key_addr,
    output logic [31:0]      src_len,
    output logic [2:0]       err_flags,
    output logic             irq
);

    logic        cmd_hit;
    logic [31:0] cmd_masked;
    logic [2:0]  dec_code;
    logic        dec_ok;
    logic        busy, finish;
    logic        irq_en, complete;

    hash_algo_decode #(.WIDE_FAMILY(WIDE)) u_decode (
        .sel_base  (cmd_masked[6:4]),
        .sel_wide  (cmd_masked[12:10]),
        .algo_code (dec_code),
        .algo_ok   (dec_ok)
    );

    hash_job_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (cmd_hit && dec_ok),
        .done_i   (job_done),
        .start_o  (job_start),
        .busy_o   (busy),
        .finish_o (finish)
    );

    hash_reg_bank #(
        .IDX_W    (IDX_W),
        .WORDS    (WORDS),
        .SRC_BITS (SRC_BITS),
        .WIDE     (WIDE)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .rd_en        (reg_rd),
        .widx         (reg_widx),
        .wdata        (reg_wdata),
        .busy_i       (busy),
        .algo_ok_i    (dec_ok),
        .algo_code_i  (dec_code),
        .finish_i     (finish),
        .cmd_hit_o    (cmd_hit),
        .cmd_masked_o (cmd_masked),
        .rdata_o      (reg_rdata),
        .src_o        (src_addr),
        .dst_o        (dst_addr),
        .key_o        (key_addr),
        .len_o        (src_len),
        .algo_o       (job_algo),
        .digest_o     (job_digest_mode),
        .sg_o         (job_sg),
        .irq_en_o     (irq_en),
        .complete_o   (complete),
        .err_o        (err_flags)
    );

    assign irq = complete & irq_en;

    // R8
    irq_needs_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> complete);

    // R6
    start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> $past(reg_wr));

    // R7
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !job_start && job_done) |=> complete);

endmodule

// File: tb/hash_cmd_regfile_bench.sv
`timescale 1ns/1ps
module hash_cmd_regfile_bench;

    localparam int IW = 10;
    localparam logic [IW-1:0] A_CIPHER = 10'd4, A_GAP = 10'd5, A_STATUS = 10'd7,
        A_SRC = 10'd8, A_DST = 10'd9, A_KEY = 10'd10, A_LEN = 10'd11, A_CMD = 10'd12,
        A_OUT1 = 10'd16, A_OUT2 = 10'd24;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, job_done = 1'b0;
    logic [IW-1:0] reg_widx = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, src_addr, dst_addr, key_addr, src_len;
    logic job_start, job_sg, irq;
    logic [2:0] job_algo, err_flags;
    logic [1:0] job_digest_mode;

    hash_cmd_regfile u_hash_cmd_regfile (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_widx(reg_widx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .job_start(job_start), .job_done(job_done),
        .job_algo(job_algo), .job_digest_mode(job_digest_mode), .job_sg(job_sg),
        .src_addr(src_addr), .dst_addr(dst_addr), .key_addr(key_addr), .src_len(src_len),
        .err_flags(err_flags), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [IW-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_widx = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [IW-1:0] a, input logic [31:0] e, input string tag);
        reg_rd = 1'b1; reg_widx = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // scoreboard monitor: read data is due one edge after the strobe
    always @(posedge clk) begin
        if (reg_rd) begin
            #1;
            if (exp_q.size() == 0) begin
                check("R2 unexpected read", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    // {ok, code} from the R4 table
    function automatic logic [3:0] ref_algo(input logic [31:0] c);
        case (c[6:4])
            3'b000: return 4'b1_000;
            3'b010: return 4'b1_001;
            3'b100: return 4'b1_010;
            3'b101: return 4'b1_011;
            3'b110: case (c[12:10])
                3'b000:  return 4'b1_100;
                3'b001:  return 4'b1_101;
                3'b010:  return 4'b1_110;
                default: return 4'b0_111;
            endcase
            default: return 4'b0_111;
        endcase
    endfunction

    task automatic run_job(input logic [31:0] c);
        logic [3:0] r = ref_algo(c);
        wr(A_CMD, c);
        check("R6 start pulse", {31'd0, job_start}, 32'd1);
        check("R4 algo code", {29'd0, job_algo}, {29'd0, r[2:0]});
        check("R6 digest mode", {30'd0, job_digest_mode}, {30'd0, c[8:7]});
        check("R6 sg bit", {31'd0, job_sg}, {31'd0, c[18]});
        @(negedge clk);
        check("R6 start single", {31'd0, job_start}, 32'd0);
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
        check("R8 irq follows enable", {31'd0, irq}, {31'd0, c[9]});
        rd_expect(A_STATUS, 32'h200, "R7 complete set");
        wr(A_STATUS, 32'h200);
        check("R9 irq cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic bad_cmd(input logic [31:0] c);
        wr(A_CMD, c);
        check("R5 no start", {31'd0, job_start}, 32'd0);
        check("R5 algo error", {29'd0, err_flags}, 32'd1);
        rd_expect(A_CMD, c & 32'h0014_7FFF, "R5 command stored");
        wr(A_STATUS, 32'h1);
        rd_expect(A_STATUS, 32'h0, "R9 algo error cleared");
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 start", {31'd0, job_start}, 32'd0);
        check("R1 errors", {29'd0, err_flags}, 32'd0);
        check("R1 rdata", reg_rdata, 32'd0);
        rd_expect(A_STATUS, 32'd0, "R1 status");
        rd_expect(A_CMD, 32'd0, "R1 command");
        rd_expect(A_SRC, 32'd0, "R1 source");

        // R2 / R3 masking and readback
        wr(A_SRC, 32'hFFFF_FFFF);
        rd_expect(A_SRC, 32'h7FFF_FFFF, "R3 source mask");
        check("R3 source port", src_addr, 32'h7FFF_FFFF);
        wr(A_DST, 32'hFFFF_FFFF);
        rd_expect(A_DST, 32'h7FFF_FFF8, "R3 destination mask");
        wr(A_KEY, 32'h1234_5677);
        rd_expect(A_KEY, 32'h1234_5670, "R3 key mask");
        wr(A_LEN, 32'hFFFF_FFFF);
        rd_expect(A_LEN, 32'h0FFF_FFFF, "R3 length mask");
        wr(A_CIPHER, 32'hA5A5_A5A5);
        rd_expect(A_CIPHER, 32'hA5A5_A5A5, "R2 cipher word");
        wr(A_GAP, 32'hFFFF_FFFF);
        rd_expect(A_GAP, 32'd0, "R2 empty index");

        // R5 invalid selections, R3 command mask
        bad_cmd(32'hFFFF_FFFF);
        bad_cmd(32'h0000_0010);
        bad_cmd(32'h0000_0C60);
        bad_cmd(32'h0000_0070);

        // R4 / R6 / R7 / R8 valid jobs
        run_job(32'h0000_0200);
        run_job(32'h0000_0020);
        run_job(32'h0000_02C0);
        run_job(32'h0000_0150);
        run_job(32'h0004_0260);
        run_job(32'h0000_0460);
        run_job(32'h0000_0A60);

        // R7 done while idle has no effect
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
        rd_expect(A_STATUS, 32'd0, "R7 stray done ignored");
        check("R7 no irq on stray done", {31'd0, irq}, 32'd0);

        // R9 writing zero keeps the flag
        wr(A_CMD, 32'h0000_0220);
        @(negedge clk);
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
        wr(A_STATUS, 32'h0000_0000);
        rd_expect(A_STATUS, 32'h200, "R9 zero write keeps flag");
        check("R9 irq kept", {31'd0, irq}, 32'd1);
        wr(A_STATUS, 32'h200);
        check("R9 irq dropped", {31'd0, irq}, 32'd0);

        // R10 command during a running job
        wr(A_CMD, 32'h0000_0020);
        @(negedge clk);
        wr(A_CMD, 32'h0000_0040);
        check("R10 busy error", {29'd0, err_flags}, 32'd4);
        rd_expect(A_CMD, 32'h0000_0020, "R10 command unchanged");
        check("R10 no restart", {31'd0, job_start}, 32'd0);
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
        wr(A_STATUS, 32'h204);
        rd_expect(A_STATUS, 32'd0, "R9 clear two bits");

        // R11 outside the window
        rd_expect(A_OUT1, 32'd0, "R11 read zero");
        check("R11 window error", {29'd0, err_flags}, 32'd2);
        wr(A_OUT2, 32'h0000_1111);
        rd_expect(A_SRC, 32'h7FFF_FFFF, "R11 write dropped");
        wr(A_STATUS, 32'h2);
        check("R11 window error cleared", {29'd0, err_flags}, 32'd0);

        // R1 reset clears stored state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_expect(A_DST, 32'd0, "R1 destination after reset");
        rd_expect(A_CIPHER, 32'd0, "R1 cipher after reset");

        @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule